// File: doc/BRIEF.md
# Button-Rate Running Light Sequencer

This block drives four LEDs as a running light. Exactly one LED is lit at a time, and the lit position moves one place along the row on every step, wrapping from the last LED back to the first. An internal step counter, clocked from the system clock, sets how often the light moves.

Two raw push-button inputs set the step rate. Each button adds its own weight to a base rate, so the rate in hertz is `BASE_HZ + W0_HZ*b0 + W1_HZ*b1`. With the default weights this gives 4 Hz with no button pressed, 12 Hz with button 0, 20 Hz with button 1, and 28 Hz with both. Each button is passed through a synchronizer before it is used.

A new rate takes effect only at a step boundary. The step already under way ends on its old period, and the LED position is never disturbed. Because `CLK_HZ` is a parameter, the block runs from any system clock, and a small clock value can be used to check the step spacing directly in clock cycles.

Top module: `run_light_seq`

## Requirements
- R1: Exactly one bit of `led_o` is high at every cycle outside reset. Bit k high means LED k is lit, and LED k corresponds to step index k.
- R2: The lit LED moves only at a step. At a step, `led_o` goes 4'b0001 -> 4'b0010 -> 4'b0100 -> 4'b1000 -> 4'b0001; between steps it holds its value.
- R3: Once a rate is in force, consecutive steps are exactly `CLK_HZ / (BASE_HZ + W0_HZ*b0 + W1_HZ*b1)` clock cycles apart, using integer division. Here b0 and b1 are 1 while the button is high. With the defaults this is 4, 12, 20 and 28 Hz for buttons {b1,b0} = 00, 01, 10 and 11.
- R4: Each button passes through a two-flop synchronizer. A button change applied at least three clock edges before a step edge sets the period of the interval that starts at that step. A change applied two edges before a step edge is not seen until the following step.
- R5: A rate change never shortens or lengthens the interval already under way. The new period starts at the next step boundary, and the LED rotation continues from its current position.
- R6: While `rst_i` is high at a clock edge, the block goes to step index 0 (`led_o` = 4'b0001), a cleared step counter and the base (no-button) period. The first step after release comes exactly base-period cycles after the release edge, whatever the button levels are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock, frequency `CLK_HZ` |
| rst_i | input | 1 | Synchronous reset, active high |
| btn0_i | input | 1 | Raw push button 0, active high, asynchronous |
| btn1_i | input | 1 | Raw push button 1, active high, asynchronous |
| led_o | output | 4 | One-hot LED drive; bit k lights LED k |

## Verification
The checker assumes that every rate the weights can produce is at least one step per `CLK_HZ` cycles and no faster than one step per clock. In other words, every computed period is a nonzero number of cycles that fits the counter width. The bench configuration (840 Hz clock) keeps all four periods between 30 and 210 cycles.

The checker also assumes that reset is held for at least one clock edge before any checked cycle. The bench drives reset high from time zero.

The buttons are asynchronous to the design. The bench nevertheless changes them only on the falling clock edge, at chosen distances from a step edge, so that the synchronizer latency lands on a known edge. It sweeps all four button combinations, and it probes both sides of the synchronizer's cut-off point.

// File: rtl/rl_pkg.sv
package rl_pkg;

    localparam int NUM_LEDS = 4;
    localparam int NUM_BTNS = 2;

    // Step period in clock cycles for one button combination (btn[0]=b0, btn[1]=b1)
    function automatic int step_period(input int clk_hz, input int base_hz,
                                       input int w0_hz, input int w1_hz,
                                       input logic [1:0] btn);
        int rate_hz;
        rate_hz = base_hz + (btn[0] ? w0_hz : 0) + (btn[1] ? w1_hz : 0);
        return clk_hz / rate_hz;
    endfunction

endpackage

// File: rtl/rl_btn_sync.sv
module rl_btn_sync #(
    parameter int NUM    = 2,
    parameter int STAGES = 2
) (
    input  logic           clk_i,
    input  logic           rst_i,
    input  logic [NUM-1:0] raw_i,
    output logic [NUM-1:0] sync_o
);

    typedef struct packed {
        logic [NUM-1:0][STAGES-1:0] chain;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int b = 0; b < NUM; b++) begin
            st_d.chain[b] = {st_q.chain[b][STAGES-2:0], raw_i[b]};
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        for (int b = 0; b < NUM; b++) begin
            sync_o[b] = st_q.chain[b][STAGES-1];
        end
    end

endmodule

// File: rtl/rl_rate_tick.sv
module rl_rate_tick
    import rl_pkg::*;
#(
    parameter int CLK_HZ  = 50_000_000,
    parameter int BASE_HZ = 4,
    parameter int W0_HZ   = 8,
    parameter int W1_HZ   = 16,
    parameter int CW      = $clog2(CLK_HZ / BASE_HZ + 1)
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic [1:0]    btn_i,
    output logic          tick_o,
    output logic [CW-1:0] period_o
);

    localparam int NUM_COMBOS = 1 << NUM_BTNS;
    localparam logic [CW-1:0] P_BASE = CW'(step_period(CLK_HZ, BASE_HZ, W0_HZ, W1_HZ, 2'b00));

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [CW-1:0] period;
    } tick_st_t;

    logic [CW-1:0] period_tbl [NUM_COMBOS];
    tick_st_t      st_d, st_q;
    logic          tick;

    // One constant period per button combination, worked out at elaboration
    for (genvar i = 0; i < NUM_COMBOS; i++) begin : g_tbl
        assign period_tbl[i] = CW'(step_period(CLK_HZ, BASE_HZ, W0_HZ, W1_HZ, 2'(i)));
    end

    always_comb begin
        st_d = st_q;
        tick = (st_q.cnt == st_q.period - CW'(1));
        if (tick) begin
            st_d.cnt    = '0;
            st_d.period = period_tbl[btn_i];
        end else begin
            st_d.cnt    = st_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q.cnt    <= '0;
            st_q.period <= P_BASE;
        end else begin
            st_q <= st_d;
        end
    end

    assign tick_o   = tick;
    assign period_o = st_q.period;

endmodule

// File: rtl/rl_step_ring.sv
module rl_step_ring #(
    parameter int NLED = 4,
    parameter int IW   = $clog2(NLED)
) (
    input  logic            clk_i,
    input  logic            rst_i,
    input  logic            adv_i,
    output logic [NLED-1:0] led_o
);

    localparam logic [IW-1:0] LAST = IW'(NLED - 1);

    typedef struct packed {
        logic [IW-1:0] idx;
    } ring_st_t;

    ring_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (adv_i) begin
            st_d.idx = (st_q.idx == LAST) ? '0 : st_q.idx + IW'(1);
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // Index decoder: one output per index value
    for (genvar k = 0; k < NLED; k++) begin : g_dec
        assign led_o[k] = (st_q.idx == IW'(k));
    end

endmodule

// File: rtl/run_light_seq.sv
module run_light_seq
    import rl_pkg::*;
#(
    parameter int CLK_HZ      = 50_000_000,
    parameter int BASE_HZ     = 4,
    parameter int W0_HZ       = 8,
    parameter int W1_HZ       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk_i,
    input  logic                rst_i,
    input  logic                btn0_i,
    input  logic                btn1_i,
    output logic [NUM_LEDS-1:0] led_o
);

    localparam int CW = $clog2(CLK_HZ / BASE_HZ + 1);

    logic [NUM_BTNS-1:0] btn_sync;
    logic                tick;
    logic [CW-1:0]       period;

    rl_btn_sync #(
        .NUM    (NUM_BTNS),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .raw_i  ({btn1_i, btn0_i}),
        .sync_o (btn_sync)
    );

    rl_rate_tick #(
        .CLK_HZ  (CLK_HZ),
        .BASE_HZ (BASE_HZ),
        .W0_HZ   (W0_HZ),
        .W1_HZ   (W1_HZ),
        .CW      (CW)
    ) u_tick (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .btn_i    (btn_sync),
        .tick_o   (tick),
        .period_o (period)
    );

    rl_step_ring #(
        .NLED (NUM_LEDS)
    ) u_ring (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .adv_i (tick),
        .led_o (led_o)
    );

endmodule

// File: rtl/run_light_seq_chk.sv
module run_light_seq_chk
    import rl_pkg::*;
#(
    parameter int CLK_HZ  = 50_000_000,
    parameter int BASE_HZ = 4,
    parameter int W0_HZ   = 8,
    parameter int W1_HZ   = 16,
    parameter int CW      = $clog2(CLK_HZ / BASE_HZ + 1)
) (
    input logic          clk_i,
    input logic          rst_i,
    input logic [3:0]    led_i,
    input logic          tick_i,
    input logic [CW-1:0] period_i
);

    localparam logic [CW-1:0] P00 = CW'(step_period(CLK_HZ, BASE_HZ, W0_HZ, W1_HZ, 2'b00));
    localparam logic [CW-1:0] P01 = CW'(step_period(CLK_HZ, BASE_HZ, W0_HZ, W1_HZ, 2'b01));
    localparam logic [CW-1:0] P10 = CW'(step_period(CLK_HZ, BASE_HZ, W0_HZ, W1_HZ, 2'b10));
    localparam logic [CW-1:0] P11 = CW'(step_period(CLK_HZ, BASE_HZ, W0_HZ, W1_HZ, 2'b11));

    assert_one_lit_R1: assert property (@(posedge clk_i) disable iff (rst_i)
        $countones(led_i) == 1);

    assert_rotate_on_step_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        tick_i |=> (led_i == {$past(led_i[2:0]), $past(led_i[3])}));

    assert_hold_between_steps_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        !tick_i |=> $stable(led_i));

    assert_period_legal_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        (period_i == P00) || (period_i == P01) || (period_i == P10) || (period_i == P11));

    assert_rate_at_boundary_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        !tick_i |=> $stable(period_i));

    assert_reset_state_R6: assert property (@(posedge clk_i)
        rst_i |=> (led_i == 4'b0001) && (period_i == P00));

endmodule

bind run_light_seq run_light_seq_chk #(
    .CLK_HZ  (CLK_HZ),
    .BASE_HZ (BASE_HZ),
    .W0_HZ   (W0_HZ),
    .W1_HZ   (W1_HZ)
) chk_i (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .led_i    (led_o),
    .tick_i   (tick),
    .period_i (period)
);

// File: tb/run_light_seq_tb_top.sv
`timescale 1ns/1ps
module run_light_seq_tb_top;

    localparam int TB_CLK_HZ = 840;
    localparam int BASE = 4;
    localparam int WB0  = 8;
    localparam int WB1  = 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       b0  = 1'b0;
    logic       b1  = 1'b0;
    logic [3:0] led;

    int n_checks = 0;
    int n_fail   = 0;
    logic [3:0] exp_led;

    always #10 clk = ~clk;   // 50 MHz

    run_light_seq #(
        .CLK_HZ  (TB_CLK_HZ),
        .BASE_HZ (BASE),
        .W0_HZ   (WB0),
        .W1_HZ   (WB1)
    ) dut_i (
        .clk_i  (clk),
        .rst_i  (rst),
        .btn0_i (b0),
        .btn1_i (b1),
        .led_o  (led)
    );

    function automatic int exp_period(input logic p0, input logic p1);
        return TB_CLK_HZ / (BASE + (p0 ? WB0 : 0) + (p1 ? WB1 : 0));
    endfunction

    function automatic logic [3:0] rot(input logic [3:0] v);
        return {v[2:0], v[3]};
    endfunction

    task automatic check(input logic ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Counts rising edges from now until led changes; sampled on falling edges
    task automatic wait_change(output int n);
        logic [3:0] prev;
        prev = led;
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (led == prev && n < 2000);
    endtask

    task automatic step_and_check(input int exp_n, input string req);
        int n;
        wait_change(n);
        check(n == exp_n, req, n, exp_n);
        exp_led = rot(exp_led);
        check(led == exp_led, "R2 rotation", int'(led), int'(exp_led));
        check($countones(led) == 1, "R1 one lit", $countones(led), 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        check(led == 4'b0001, "R6 reset state", int'(led), 1);
        rst = 1'b0;
        exp_led = 4'b0001;

        // R6: first step comes base period after release
        step_and_check(exp_period(0, 0), "R6 first step");
        step_and_check(exp_period(0, 0), "R3 rate none");

        // R3/R5 sweep over every button combination
        for (int c = 1; c < 5; c++) begin
            logic [1:0] prev_c, cur_c;
            prev_c = 2'(c - 1);
            cur_c  = 2'(c % 4);
            b0 = cur_c[0];
            b1 = cur_c[1];
            step_and_check(exp_period(prev_c[0], prev_c[1]), "R5 old period completes");
            for (int k = 0; k < 3; k++) begin
                step_and_check(exp_period(cur_c[0], cur_c[1]), "R3 rate per combo");
            end
        end

        // Now no buttons pressed (210). R4: change 3 edges before step edge -> applies
        b0 = 1'b1; b1 = 1'b1;
        step_and_check(exp_period(0, 0), "R5 old period");
        step_and_check(exp_period(1, 1), "R3 rate both");
        repeat (exp_period(1, 1) - 3) @(negedge clk);
        b0 = 1'b0; b1 = 1'b0;
        step_and_check(3, "R4 remainder");
        step_and_check(exp_period(0, 0), "R4 sync in time");

        // R4: change 2 edges before step edge -> too late for this boundary
        repeat (exp_period(0, 0) - 2) @(negedge clk);
        b0 = 1'b1;
        step_and_check(2, "R4 remainder");
        step_and_check(exp_period(0, 0), "R4 sync too late");
        step_and_check(exp_period(1, 0), "R4 applied next");

        // R6: mid-run reset with button 1 held
        b0 = 1'b0; b1 = 1'b1;
        repeat (7) @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check(led == 4'b0001, "R6 mid-run reset", int'(led), 1);
        rst = 1'b0;
        exp_led = 4'b0001;
        step_and_check(exp_period(0, 0), "R6 base period after reset");
        step_and_check(exp_period(0, 1), "R3 rate b1");

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule